// File: doc/BRIEF.md
# Subtract-and-Branch-if-Nonpositive Processor Core

This block is a tiny processor with a single instruction and no opcode. Each instruction is three consecutive words of memory, read in order: a source address, a destination address and a branch target. The core reads the word at the source address and the word at the destination address. It writes the destination word minus the source word back to the destination. If that difference is zero or negative, it jumps to the branch target. Otherwise it moves on to the next three-word group. Program and data share one word-addressed memory, so an instruction can rewrite the operands of instructions that run after it.

The memory sits outside the core and is reached through one synchronous single-port interface. A read returns its data in the cycle after the address is presented. A write happens at the clock edge that ends the cycle in which the write strobe is high. One instruction therefore takes six memory cycles plus one boundary cycle. A step-enable input gates the start of every instruction, so a caller can single-step the machine or let it run freely.

Negative operand addresses, and a taken jump to a negative target, stop the machine cleanly. Out-of-range addresses also stop the machine, and they set a fault flag as well. The halt flag and the final program counter are the result of a run.

Top module: `sbz_core`

## Requirements
- R1: After reset, the core is not halted, the fault flag is 0, final_pc is 0 and there is no write strobe. Execution starts at address 0.
- R2: For an instruction at PC, the operands a, b and c are read from PC, PC+1 and PC+2. The value Mem[b] minus Mem[a] is written to address b. This is exactly one write per executed instruction.
- R3: The subtraction wraps modulo 2^W. The branch test uses the wrapped two's-complement result. With W=16, 0x8000 minus 1 gives 0x7FFF (positive), and 0 minus 0x8000 gives 0x8000 (negative).
- R4: A result less than or equal to zero (a zero result included) loads PC with c. A positive result loads PC with PC+3.
- R5: If operand a or operand b is negative (sign bit set), the core halts without any write. final_pc keeps the PC of that instruction and fault stays 0. A negative operand takes precedence over an out-of-range one.
- R6: A taken branch to a negative c halts the core with final_pc equal to c and fault 0. A branch that is not taken with a negative c continues at PC+3.
- R7: If a non-negative a or b is at least DEPTH, the core halts with fault 1 and no write. It also halts with fault 1 when an instruction would be fetched with PC+2 at least DEPTH; final_pc then shows that PC.
- R8: A write that changes an operand of a later instruction takes effect when that instruction is fetched (self-modifying code).
- R9: An instruction starts only when step_en is high at an instruction boundary. A one-cycle pulse runs exactly one instruction. With step_en low, the core does nothing.
- R10: Once halted, the core stays halted, final_pc holds its value and no write occurs, whatever step_en does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| step_en | input | 1 | Allows the next instruction to start |
| mem_addr | output | $clog2(DEPTH) | Memory word address |
| mem_we | output | 1 | Write strobe for the current cycle |
| mem_wdata | output | W | Write data (difference) |
| mem_rdata | input | W | Read data, for the address of the previous cycle |
| halted | output | 1 | Machine has stopped |
| fault | output | 1 | Stop was caused by an out-of-range address |
| final_pc | output | W | Program counter (final value once halted) |

## Verification
Short programs in a memory model test the arithmetic with a positive difference, a negative difference, an exactly zero difference and both wrap-around directions. These separate the not-taken path, the taken path and the signed test of the wrapped result. The halt paths are covered with a negative source, a negative destination, a negative branch target (taken and not taken), an out-of-range destination, a fetch past the end of memory, and a negative operand paired with an out-of-range one. These distinguish clean stops from faults and show which check has priority. A program that rewrites the branch target of the instruction after it proves that operands are fetched fresh. Single pulses on step_en, followed by a long hold, show that exactly one instruction runs per pulse and that a halted core stays frozen.

// File: rtl/sbz_pkg.sv
package sbz_pkg;
  // Instruction phases: three operand fetches, two data reads, one write.
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FA,
    ST_FB,
    ST_FC,
    ST_RA,
    ST_RB,
    ST_WR,
    ST_HALT
  } sbz_state_e;
endpackage

// File: rtl/sbz_addr_check.sv
module sbz_addr_check #(
  parameter int W     = 16,
  parameter int DEPTH = 64
) (
  input  logic [W-1:0] val,
  output logic         neg,
  output logic         oob
);
  localparam logic [W-1:0] LIMIT = W'(DEPTH);

  always_comb begin
    neg = val[W-1];
    oob = !val[W-1] && (val >= LIMIT);
  end
endmodule

// File: rtl/sbz_alu.sv
module sbz_alu #(
  parameter int W = 16
) (
  input  logic [W-1:0] minuend,
  input  logic [W-1:0] subtrahend,
  output logic [W-1:0] diff,
  output logic         nonpos
);
  always_comb begin
    diff   = minuend - subtrahend;
    nonpos = diff[W-1] || (diff == '0);
  end
endmodule

// File: rtl/sbz_fsm.sv
module sbz_fsm
  import sbz_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       step_en,
  input  logic       fetch_bad,
  input  logic       opnd_neg,
  input  logic       opnd_oob,
  input  logic       take,
  input  logic       c_neg,
  output sbz_state_e state
);
  sbz_state_e state_d;

  always_comb begin
    state_d = state;
    unique case (state)
      ST_IDLE: if (step_en) state_d = fetch_bad ? ST_HALT : ST_FA;
      ST_FA:   state_d = ST_FB;
      ST_FB:   state_d = ST_FC;
      ST_FC:   state_d = (opnd_neg || opnd_oob) ? ST_HALT : ST_RA;
      ST_RA:   state_d = ST_RB;
      ST_RB:   state_d = ST_WR;
      ST_WR:   state_d = (take && c_neg) ? ST_HALT : ST_IDLE;
      ST_HALT: state_d = ST_HALT;
      default: state_d = ST_HALT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_d;
  end
endmodule

// File: rtl/sbz_core.sv
module sbz_core
  import sbz_pkg::*;
#(
  parameter int W     = 16,
  parameter int DEPTH = 64
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     step_en,
  output logic [$clog2(DEPTH)-1:0] mem_addr,
  output logic                     mem_we,
  output logic [W-1:0]             mem_wdata,
  input  logic [W-1:0]             mem_rdata,
  output logic                     halted,
  output logic                     fault,
  output logic [W-1:0]             final_pc
);
  localparam int AW    = $clog2(DEPTH);
  localparam int NCHK  = 3; // operand a, operand b, fetch tail PC+2

  sbz_state_e    state;
  logic [W-1:0]  pc_q, a_q, c_q, va_q;
  logic [AW-1:0] b_q;
  logic          fault_q;
  logic [W-1:0]  pc_tail;
  logic [W-1:0]  chk_val [NCHK];
  logic [NCHK-1:0] neg_v, oob_v;
  logic          opnd_neg, opnd_oob, fetch_bad;
  logic [W-1:0]  diff;
  logic          nonpos;

  // Address classification for both operands and the fetch window.
  always_comb begin
    pc_tail    = pc_q + W'(2);
    chk_val[0] = a_q;
    chk_val[1] = mem_rdata;
    chk_val[2] = pc_tail;
  end

  for (genvar i = 0; i < NCHK; i++) begin : g_chk
    sbz_addr_check #(.W(W), .DEPTH(DEPTH)) u_chk (
      .val (chk_val[i]),
      .neg (neg_v[i]),
      .oob (oob_v[i])
    );
  end

  always_comb begin
    opnd_neg  = neg_v[0] || neg_v[1];
    opnd_oob  = oob_v[0] || oob_v[1];
    fetch_bad = neg_v[2] || oob_v[2];
  end

  sbz_alu #(.W(W)) u_alu (
    .minuend    (mem_rdata),
    .subtrahend (va_q),
    .diff       (diff),
    .nonpos     (nonpos)
  );

  sbz_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_en   (step_en),
    .fetch_bad (fetch_bad),
    .opnd_neg  (opnd_neg),
    .opnd_oob  (opnd_oob),
    .take      (nonpos),
    .c_neg     (c_q[W-1]),
    .state     (state)
  );

  // Next-state values and clock enables for the datapath registers.
  logic          pc_en, a_en, b_en, c_en, va_en, fault_en;
  logic [W-1:0]  pc_d;

  always_comb begin
    a_en     = (state == ST_FB);
    b_en     = (state == ST_FC);
    c_en     = (state == ST_RA);
    va_en    = (state == ST_RB);
    pc_en    = (state == ST_WR);
    pc_d     = nonpos ? c_q : (pc_q + W'(3));
    fault_en = ((state == ST_IDLE) && step_en && fetch_bad) ||
               ((state == ST_FC) && !opnd_neg && opnd_oob);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q    <= '0;
      a_q     <= '0;
      b_q     <= '0;
      c_q     <= '0;
      va_q    <= '0;
      fault_q <= 1'b0;
    end else begin
      if (pc_en)    pc_q    <= pc_d;
      if (a_en)     a_q     <= mem_rdata;
      if (b_en)     b_q     <= mem_rdata[AW-1:0];
      if (c_en)     c_q     <= mem_rdata;
      if (va_en)    va_q    <= mem_rdata;
      if (fault_en) fault_q <= 1'b1;
    end
  end

  // Memory port: address chosen by phase, write only in the last phase.
  always_comb begin
    unique case (state)
      ST_FA:        mem_addr = pc_q[AW-1:0];
      ST_FB:        mem_addr = pc_q[AW-1:0] + AW'(1);
      ST_FC:        mem_addr = pc_q[AW-1:0] + AW'(2);
      ST_RA:        mem_addr = a_q[AW-1:0];
      ST_RB, ST_WR: mem_addr = b_q;
      default:      mem_addr = pc_q[AW-1:0];
    endcase
    mem_we    = (state == ST_WR);
    mem_wdata = diff;
    halted    = (state == ST_HALT);
    fault     = fault_q;
    final_pc  = pc_q;
  end
endmodule

// File: rtl/sbz_core_chk.sv
module sbz_core_chk #(
  parameter int W     = 16,
  parameter int DEPTH = 64
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [$clog2(DEPTH)-1:0] mem_addr,
  input logic                     mem_we,
  input logic                     halted,
  input logic                     fault,
  input logic [W-1:0]             final_pc
);
  // R10: the stop state is permanent
  a_r10_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);
  // R10: the reported program counter is frozen after the stop
  a_r10_pc_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> $stable(final_pc));
  // R10: a stopped core never writes
  a_r10_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !mem_we);
  // R7: a fault only appears together with the stop
  a_r7_fault_halts: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> halted);
  // R2: one write per instruction, never back to back
  a_r2_single_write: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);
  // R2: the write goes to the destination word read in the cycle before
  a_r2_write_dest: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr == $past(mem_addr)));
endmodule

bind sbz_core sbz_core_chk #(.W(W), .DEPTH(DEPTH)) u_sbz_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mem_addr (mem_addr),
  .mem_we   (mem_we),
  .halted   (halted),
  .fault    (fault),
  .final_pc (final_pc)
);

// File: tb/sim_sbz_core.sv
module sim_sbz_core;
  localparam int W     = 16;
  localparam int DEPTH = 64;
  localparam int AW    = $clog2(DEPTH);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          step_en;
  logic [AW-1:0] mem_addr;
  logic          mem_we;
  logic [W-1:0]  mem_wdata;
  logic [W-1:0]  mem_rdata;
  logic          halted, fault;
  logic [W-1:0]  final_pc;

  always #4 clk = ~clk; // 125 MHz

  sbz_core #(.W(W), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .step_en(step_en),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .halted(halted), .fault(fault), .final_pc(final_pc)
  );

  // Memory model: synchronous single port, read data one cycle later.
  logic [W-1:0] mem [DEPTH];
  int wr_cnt = 0;
  always @(posedge clk) begin
    if (mem_we) begin
      mem[mem_addr] <= mem_wdata;
      wr_cnt <= wr_cnt + 1;
    end
    mem_rdata <= mem[mem_addr];
  end

  int n_chk = 0;
  int n_fail = 0;
  int done_cnt = 0;
  int wr_base = 0;

  typedef struct {
    logic [W-1:0] pc;
    logic         flt;
    int           a0;
    logic [W-1:0] v0;
    int           a1;
    logic [W-1:0] v1;
    int           wr;
  } exp_t;
  exp_t  exp_q [$];
  string tag_q [$];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // Monitor: pops the expected outcome when the core stops.
  initial begin
    forever begin
      @(posedge halted);
      @(negedge clk);
      if (exp_q.size() == 0) begin
        check(1'b0, "R10", "unexpected halt", {16'h0, final_pc}, 32'h0);
      end else begin
        exp_t  e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(final_pc == e.pc, t, "final_pc", {16'h0, final_pc}, {16'h0, e.pc});
        check(fault == e.flt, t, "fault", {31'h0, fault}, {31'h0, e.flt});
        check(mem[e.a0] == e.v0, t, "mem word 0", {16'h0, mem[e.a0]}, {16'h0, e.v0});
        check(mem[e.a1] == e.v1, t, "mem word 1", {16'h0, mem[e.a1]}, {16'h0, e.v1});
        check((wr_cnt - wr_base) == e.wr, t, "write count", wr_cnt - wr_base, e.wr);
      end
      done_cnt++;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "R9", "watchdog expired", 32'h0, 32'h1);
    finish_run();
  end

  task automatic begin_case();
    @(negedge clk);
    rst_n   = 1'b0;
    step_en = 1'b0;
    for (int i = 0; i < DEPTH; i++) mem[i] = '1;
  endtask

  task automatic put(input int addr, input int v);
    mem[addr] = W'(v);
  endtask

  task automatic release_rst();
    @(negedge clk);
    rst_n = 1'b1;
    wr_base = wr_cnt;
  endtask

  // Driver: pushes the expected outcome, then lets the core run freely.
  task automatic run_case(input int pc, input bit flt, input int a0, input int v0,
                          input int a1, input int v1, input int wr, input string tag);
    exp_t e;
    int   target;
    e.pc = W'(pc); e.flt = flt; e.a0 = a0; e.v0 = W'(v0);
    e.a1 = a1; e.v1 = W'(v1); e.wr = wr;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    target = done_cnt + 1;
    release_rst();
    @(negedge clk);
    step_en = 1'b1;
    wait (done_cnt == target);
    @(negedge clk);
    step_en = 1'b0;
  endtask

  task automatic pulse_step();
    @(negedge clk);
    step_en = 1'b1;
    @(negedge clk);
    step_en = 1'b0;
    repeat (12) @(negedge clk);
  endtask

  initial begin
    rst_n   = 1'b0;
    step_en = 1'b0;

    // R1 reset state and R9 no progress without step_en
    begin_case();
    put(0, 30); put(1, 31); put(2, 3); put(30, 5); put(31, 12);
    repeat (2) @(negedge clk);
    release_rst();
    check(!halted, "R1", "halted after reset", {31'h0, halted}, 0);
    check(!fault, "R1", "fault after reset", {31'h0, fault}, 0);
    check(final_pc == 0, "R1", "pc after reset", {16'h0, final_pc}, 0);
    check(!mem_we && mem_addr == 0, "R1", "idle port", {25'h0, mem_we, mem_addr}, 0);
    repeat (20) @(negedge clk);
    check(wr_cnt == wr_base && final_pc == 0, "R9", "idle without step",
          wr_cnt - wr_base, 0);

    // R2 R4 R5: positive difference falls through, then negative a stops at 3
    begin_case();
    put(0, 30); put(1, 31); put(2, 20); put(30, 5); put(31, 12);
    run_case(3, 0, 31, 7, 30, 5, 1, "R2/R4 fallthrough R5 stop");

    // R4: negative difference branches to 9
    begin_case();
    put(0, 30); put(1, 31); put(2, 9); put(30, 12); put(31, 5);
    put(3, 40); put(4, 40); put(5, 3); put(40, 0);
    run_case(9, 0, 31, -7, 40, 0, 1, "R4 taken");

    // R4: zero difference counts as taken
    begin_case();
    put(0, 30); put(1, 31); put(2, 9); put(30, 8); put(31, 8);
    put(3, 40); put(4, 40); put(5, 3); put(40, 0);
    run_case(9, 0, 31, 0, 30, 8, 1, "R4 zero");

    // R3: wrap in both directions
    begin_case();
    put(0, 30); put(1, 31); put(2, 20); put(30, 1); put(31, 16'h8000);
    put(3, 32); put(4, 33); put(5, 12); put(32, 16'h8000); put(33, 0);
    run_case(12, 0, 31, 16'h7FFF, 33, 16'h8000, 2, "R3 wrap");

    // R6: not taken with negative c continues, taken with negative c stops
    begin_case();
    put(0, 30); put(1, 32); put(2, -7); put(30, 1); put(32, 10);
    put(3, 30); put(4, 31); put(5, -5); put(31, 1);
    run_case(-5, 0, 32, 9, 31, 0, 2, "R6 negative target");

    // R5: negative destination stops before any write
    begin_case();
    put(0, 30); put(1, -2); put(2, 5); put(30, 7);
    run_case(0, 0, 30, 7, 1, -2, 0, "R5 negative b");

    // R7: destination beyond memory depth
    begin_case();
    put(0, 30); put(1, 64); put(2, 3); put(30, 7);
    run_case(0, 1, 30, 7, 0, 30, 0, "R7 operand out of range");

    // R7: branch to 62 makes the fetch window run past the end
    begin_case();
    put(0, 40); put(1, 40); put(2, 62); put(40, 0);
    run_case(62, 1, 40, 0, 2, 62, 1, "R7 fetch past end");

    // R5: negative operand wins over out-of-range operand
    begin_case();
    put(0, 64); put(1, -3); put(2, 3);
    run_case(0, 0, 0, 64, 1, -3, 0, "R5 precedence");

    // R8: first instruction rewrites the branch target of the second
    begin_case();
    put(0, 30); put(1, 5); put(2, 3); put(30, 8);
    put(3, 31); put(4, 32); put(5, 20); put(31, 4); put(32, 4);
    run_case(12, 0, 5, 12, 32, 0, 2, "R8 self-modifying");

    // R9: single pulses run one instruction each
    begin_case();
    put(0, 30); put(1, 31); put(2, 3); put(3, 30); put(4, 31); put(5, 6);
    put(30, 1); put(31, 10);
    release_rst();
    pulse_step();
    check(!halted && mem[31] == 9 && final_pc == 3, "R9", "first step",
          {16'h0, mem[31]}, 9);
    check(wr_cnt - wr_base == 1, "R9", "writes after first step", wr_cnt - wr_base, 1);
    pulse_step();
    check(!halted && mem[31] == 8 && final_pc == 6, "R9", "second step",
          {16'h0, mem[31]}, 8);
    begin
      exp_t e;
      int   target;
      e.pc = 6; e.flt = 0; e.a0 = 31; e.v0 = 8; e.a1 = 30; e.v1 = 1; e.wr = 2;
      exp_q.push_back(e);
      tag_q.push_back("R9 run to stop");
      target = done_cnt + 1;
      @(negedge clk);
      step_en = 1'b1;
      wait (done_cnt == target);
    end

    // R10: held step_en after the stop changes nothing
    repeat (10) @(negedge clk);
    check(halted && final_pc == 6, "R10", "sticky stop", {16'h0, final_pc}, 6);
    check(wr_cnt - wr_base == 2, "R10", "no write after stop", wr_cnt - wr_base, 2);
    step_en = 1'b0;

    finish_run();
  end
endmodule